// File: doc/BRIEF.md
# Complementary PWM Output Stage with Break

This block sits between a PWM comparator and the two pads of a half-bridge. It takes one reference waveform and produces a main output and a complementary output. Each output has a data level and a drive-enable flag, so a pad that is left floating shows as drive-enable low with data 0. Per-output polarity bits set which level counts as inactive: an output is active when its level differs from its polarity bit.

While the block runs (main enable set), a control decode picks for each output one of four behaviours: floating, held at its inactive level, following the reference with polarity, or following the reference as one half of a complementary pair with dead-time. A dead-time counter, loaded with a programmable count of clock cycles on every reference change, delays each output's move into the active state. The main enable is a register set and cleared by software writes. A break input clears it on the next clock edge and also gates the outputs at once, with no clock delay. When the main enable is off and the idle off-state select is set, both outputs are first held at their inactive levels and, one dead-time later, move to programmed idle levels, unless those idle levels would make both outputs active together.

The PWM counter, break-source filtering and any register bus lie outside the block.

Top module: `comp_pwm_drive`

## Requirements
- R1: After reset the main enable reads 0. With the idle off-state select at 0, both drive-enables are then 0 and both data levels 0.
- R2: With main enable on and both channel enables 0, both outputs float (drive-enable 0, data 0) whatever the run off-state select is.
- R3: With main enable on and exactly one channel enable set, the enabled output drives the reference, as sampled at the previous rising clock edge, XOR its polarity bit. The other output floats with data 0 when the run off-state select is 0, and is driven at its polarity bit when that select is 1.
- R4: With main enable on and both channel enables set, the main output is active when the sampled reference is 1 and the complementary one is active when it is 0. An output leaves the active state at the edge that samples a reference change. It enters the active state D rising edges later, where D is the dead-time input (D = 0 means the same edge).
- R5: A reference level held for fewer than D cycles never makes the corresponding output active in paired mode.
- R6: With main enable off, both outputs float with data 0 when the idle off-state select is 0 or both channel enables are 0.
- R7: With main enable off, the idle off-state select 1 and at least one channel enable set, both outputs are driven. They sit at their polarity bits at once, without a clock edge, and take their idle-level bits from the (D+1)th rising edge after the main enable went off.
- R8: If the idle-level bits would make both outputs active together, both outputs stay at their polarity bits in the idle state.
- R9: The break input forces the main enable off combinationally and clears the main enable register at the next rising edge. A set write while break is 1 has no effect.
- R10: With break at 0, a set write turns the main enable on and a clear write turns it off. Set takes priority when both are written together.
- R11: The two outputs are never both driven and both active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | PWM reference waveform |
| en_p_i | input | 1 | Main output channel enable |
| en_n_i | input | 1 | Complementary output channel enable |
| pol_p_i | input | 1 | Main output polarity (inactive level) |
| pol_n_i | input | 1 | Complementary output polarity (inactive level) |
| idle_p_i | input | 1 | Main output idle level |
| idle_n_i | input | 1 | Complementary output idle level |
| run_off_i | input | 1 | Off-state select while main enable is on |
| idle_off_i | input | 1 | Off-state select while main enable is off |
| dtime_i | input | DT_W | Dead-time in clock cycles |
| moe_set_i | input | 1 | Software write: set main enable |
| moe_clr_i | input | 1 | Software write: clear main enable |
| brk_i | input | 1 | Break input, active high |
| moe_o | output | 1 | Main enable register state |
| out_p_o | output | 1 | Main output data level |
| out_p_oe_o | output | 1 | Main output drive-enable |
| out_n_o | output | 1 | Complementary output data level |
| out_n_oe_o | output | 1 | Complementary output drive-enable |

## Verification
The assertions check on every cycle that the two outputs are never active together, that the outputs float while the block is off without an idle off-state select, that break forces the inactive levels and clears the main enable, that the enable rises only on a set write, and that no output or idle level appears before its wait has run out. The exact decode of all 32 combinations of main enable, off-state selects and channel enables, the dead-time length counted in edges, suppression of short pulses, and the moment idle levels take over can only be shown by the bench's scenarios, since each needs a known expected value over a stretch of cycles.

// File: rtl/comp_pwm_pkg.sv
package comp_pwm_pkg;

  // Per-output behaviour while the main enable is on
  typedef enum logic [1:0] {
    DRV_HIZ   = 2'd0,
    DRV_INACT = 2'd1,
    DRV_REF   = 2'd2,
    DRV_PAIR  = 2'd3
  } drv_mode_e;

  // Decode of the run-state behaviour for one output
  function automatic drv_mode_e run_mode(input logic own_en,
                                         input logic other_en,
                                         input logic run_off);
    if (own_en && other_en)        return DRV_PAIR;
    else if (own_en)               return DRV_REF;
    else if (other_en && run_off)  return DRV_INACT;
    else                           return DRV_HIZ;
  endfunction

  // An output is active when its level differs from its polarity bit
  function automatic logic is_active(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction

  // Idle levels are usable only if they do not make both outputs active
  function automatic logic idle_pair_ok(input logic idle_p, input logic pol_p,
                                        input logic idle_n, input logic pol_n);
    return !(is_active(idle_p, pol_p) && is_active(idle_n, pol_n));
  endfunction

  // Next value of a down-counter that reloads on a trigger
  function automatic logic [15:0] dt_next(input logic [15:0] cur,
                                          input logic        reload,
                                          input logic [15:0] load_val);
    if (reload)          return load_val;
    else if (cur != '0)  return cur - 16'd1;
    else                 return cur;
  endfunction

endpackage

// File: rtl/cpd_moe_ctrl.sv
module cpd_moe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic brk_i,
  output logic moe_q_o,
  output logic moe_eff_o
);

  logic moe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      moe_q <= 1'b0;
    else if (brk_i)  moe_q <= 1'b0;
    else if (set_i)  moe_q <= 1'b1;
    else if (clr_i)  moe_q <= 1'b0;
  end

  assign moe_q_o   = moe_q;
  assign moe_eff_o = moe_q & ~brk_i;

  // R9: break clears the register at the next edge
  a_r9_brk_clears: assert property (@(posedge clk) disable iff (!rst_n)
    brk_i |=> !moe_q);

  // R10: the enable rises only on a set write without break
  a_r10_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(moe_q) |-> ($past(set_i) && !$past(brk_i)));

endmodule

// File: rtl/cpd_deadtime.sv
module cpd_deadtime #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dtime_i,
  output logic            ref_q_o,
  output logic            p_act_o,
  output logic            n_act_o
);
  import comp_pwm_pkg::*;

  logic            ref_q;
  logic [DT_W-1:0] cnt;
  logic            ref_edge;
  logic            dt_done;
  logic [15:0]     cnt_nxt;

  assign ref_edge = ref_i ^ ref_q;
  assign cnt_nxt  = dt_next(16'(cnt), ref_edge, 16'(dtime_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_q <= ref_i;
      cnt   <= cnt_nxt[DT_W-1:0];
    end
  end

  assign dt_done = (cnt == '0);
  assign ref_q_o = ref_q;
  assign p_act_o = ref_q & dt_done;
  assign n_act_o = ~ref_q & dt_done;

  // R4: the main side turns active only after a wait at high reference
  a_r4_p_rise_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_act_o) |-> ($past(ref_q) || ($past(dtime_i) == '0)));

  // R4: the complementary side turns active only after a wait at low reference
  a_r4_n_rise_waits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(n_act_o) |-> (!$past(ref_q) || ($past(dtime_i) == '0)));

endmodule

// File: rtl/cpd_idle_timer.sv
module cpd_idle_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            moe_eff_i,
  input  logic [DT_W-1:0] dtime_i,
  output logic            ready_o
);
  import comp_pwm_pkg::*;

  logic [DT_W-1:0] cnt;
  logic            ready_q;
  logic [15:0]     cnt_nxt;

  assign cnt_nxt = dt_next(16'(cnt), moe_eff_i, 16'(dtime_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt     <= cnt_nxt[DT_W-1:0];
      ready_q <= ~moe_eff_i & (cnt == '0);
    end
  end

  assign ready_o = ready_q & ~moe_eff_i;

  // R7: idle levels never appear unless the enable was already off
  a_r7_idle_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !$past(moe_eff_i));

endmodule

// File: rtl/cpd_out_sel.sv
module cpd_out_sel (
  input  logic moe_eff_i,
  input  logic idle_off_i,
  input  logic run_off_i,
  input  logic own_en_i,
  input  logic other_en_i,
  input  logic pol_i,
  input  logic idle_lvl_i,
  input  logic idle_ok_i,
  input  logic idle_ready_i,
  input  logic ref_q_i,
  input  logic pair_act_i,
  output logic lvl_o,
  output logic oe_o
);
  import comp_pwm_pkg::*;

  drv_mode_e mode;
  assign mode = run_mode(own_en_i, other_en_i, run_off_i);

  always_comb begin
    lvl_o = 1'b0;
    oe_o  = 1'b0;
    if (moe_eff_i) begin
      case (mode)
        DRV_INACT: begin oe_o = 1'b1; lvl_o = pol_i; end
        DRV_REF:   begin oe_o = 1'b1; lvl_o = ref_q_i ^ pol_i; end
        DRV_PAIR:  begin oe_o = 1'b1; lvl_o = pair_act_i ^ pol_i; end
        default:   begin oe_o = 1'b0; lvl_o = 1'b0; end
      endcase
    end else if (idle_off_i && (own_en_i || other_en_i)) begin
      oe_o  = 1'b1;
      lvl_o = (idle_ready_i && idle_ok_i) ? idle_lvl_i : pol_i;
    end
  end

endmodule

// File: rtl/comp_pwm_drive.sv
module comp_pwm_drive #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_i,
  input  logic            en_p_i,
  input  logic            en_n_i,
  input  logic            pol_p_i,
  input  logic            pol_n_i,
  input  logic            idle_p_i,
  input  logic            idle_n_i,
  input  logic            run_off_i,
  input  logic            idle_off_i,
  input  logic [DT_W-1:0] dtime_i,
  input  logic            moe_set_i,
  input  logic            moe_clr_i,
  input  logic            brk_i,
  output logic            moe_o,
  output logic            out_p_o,
  output logic            out_p_oe_o,
  output logic            out_n_o,
  output logic            out_n_oe_o
);
  import comp_pwm_pkg::*;

  localparam int NUM_OUT = 2;

  logic moe_eff;
  logic ref_q;
  logic p_act, n_act;
  logic idle_ready;
  logic idle_ok;

  logic [NUM_OUT-1:0] en_v, pol_v, idle_v, pair_v, lvl_v, oe_v;

  assign en_v   = {en_n_i, en_p_i};
  assign pol_v  = {pol_n_i, pol_p_i};
  assign idle_v = {idle_n_i, idle_p_i};
  assign pair_v = {n_act, p_act};
  assign idle_ok = idle_pair_ok(idle_p_i, pol_p_i, idle_n_i, pol_n_i);

  cpd_moe_ctrl i_moe (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (moe_set_i),
    .clr_i     (moe_clr_i),
    .brk_i     (brk_i),
    .moe_q_o   (moe_o),
    .moe_eff_o (moe_eff)
  );

  cpd_deadtime #(.DT_W(DT_W)) i_dt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_i   (ref_i),
    .dtime_i (dtime_i),
    .ref_q_o (ref_q),
    .p_act_o (p_act),
    .n_act_o (n_act)
  );

  cpd_idle_timer #(.DT_W(DT_W)) i_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .moe_eff_i (moe_eff),
    .dtime_i   (dtime_i),
    .ready_o   (idle_ready)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    cpd_out_sel i_sel (
      .moe_eff_i    (moe_eff),
      .idle_off_i   (idle_off_i),
      .run_off_i    (run_off_i),
      .own_en_i     (en_v[g]),
      .other_en_i   (en_v[NUM_OUT-1-g]),
      .pol_i        (pol_v[g]),
      .idle_lvl_i   (idle_v[g]),
      .idle_ok_i    (idle_ok),
      .idle_ready_i (idle_ready),
      .ref_q_i      (ref_q),
      .pair_act_i   (pair_v[g]),
      .lvl_o        (lvl_v[g]),
      .oe_o         (oe_v[g])
    );
  end

  assign out_p_o    = lvl_v[0];
  assign out_p_oe_o = oe_v[0];
  assign out_n_o    = lvl_v[1];
  assign out_n_oe_o = oe_v[1];

  // R11: never both outputs driven active together
  a_r11_no_dual_active: assert property (@(posedge clk) disable iff (!rst_n)
    (out_p_oe_o && out_n_oe_o) |->
      !(is_active(out_p_o, pol_p_i) && is_active(out_n_o, pol_n_i)));

  // R6: floating outputs while off without idle off-state
  a_r6_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe_eff && !idle_off_i) |-> (!out_p_oe_o && !out_n_oe_o && !out_p_o && !out_n_o));

  // R9: break forces the inactive levels before the idle wait ends
  a_r9_break_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_i && idle_off_i && (en_p_i || en_n_i) && !idle_ready) |->
      (out_p_oe_o && out_n_oe_o && (out_p_o == pol_p_i) && (out_n_o == pol_n_i)));

endmodule

// File: tb/test_comp_pwm_drive.sv
module test_comp_pwm_drive;

  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0, en_p = 1'b0, en_n = 1'b0;
  logic pol_p = 1'b0, pol_n = 1'b0, idle_p = 1'b0, idle_n = 1'b0;
  logic run_off = 1'b0, idle_off = 1'b0;
  logic [DT_W-1:0] dtime = '0;
  logic moe_set = 1'b0, moe_clr = 1'b0, brk = 1'b0;
  logic moe, out_p, out_p_oe, out_n, out_n_oe;

  int n_chk = 0, n_bad = 0, n_overlap = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_pwm_drive #(.DT_W(DT_W)) i_comp_pwm_drive (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .en_p_i(en_p), .en_n_i(en_n),
    .pol_p_i(pol_p), .pol_n_i(pol_n), .idle_p_i(idle_p), .idle_n_i(idle_n),
    .run_off_i(run_off), .idle_off_i(idle_off), .dtime_i(dtime),
    .moe_set_i(moe_set), .moe_clr_i(moe_clr), .brk_i(brk), .moe_o(moe),
    .out_p_o(out_p), .out_p_oe_o(out_p_oe), .out_n_o(out_n), .out_n_oe_o(out_n_oe)
  );

  // {moe, run_off, idle_off, en_p, en_n, oe_p, p, oe_n, n}
  // steady state: ref=1, pol_p=0, pol_n=1, idle_p=1, idle_n=1
  localparam logic [8:0] VEC [32] = '{
    9'b00000_0000, 9'b00001_0000, 9'b00010_0000, 9'b00011_0000,
    9'b00100_0000, 9'b00101_1111, 9'b00110_1111, 9'b00111_1111,
    9'b01000_0000, 9'b01001_0000, 9'b01010_0000, 9'b01011_0000,
    9'b01100_0000, 9'b01101_1111, 9'b01110_1111, 9'b01111_1111,
    9'b10000_0000, 9'b10001_0010, 9'b10010_1100, 9'b10011_1111,
    9'b10100_0000, 9'b10101_0010, 9'b10110_1100, 9'b10111_1111,
    9'b11000_0000, 9'b11001_1010, 9'b11010_1111, 9'b11011_1111,
    9'b11100_0000, 9'b11101_1010, 9'b11110_1111, 9'b11111_1111
  };

  function automatic string vec_tag(input logic [4:0] s);
    if (!s[4]) return (s[2] && s[1:0] != 2'b00) ? "R7" : "R6";
    if (s[1:0] == 2'b00) return "R2";
    if (s[1:0] == 2'b11) return "R4";
    return "R3";
  endfunction

  function automatic logic [3:0] obs();
    return {out_p_oe, out_p, out_n_oe, out_n};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_moe(input logic s, input logic c);
    moe_set = s; moe_clr = c;
    @(negedge clk);
    moe_set = 1'b0; moe_clr = 1'b0;
  endtask

  // R11: watch for both outputs active at once, sampled before inputs move
  always @(posedge clk)
    if (rst_n && out_p_oe && out_n_oe && (out_p ^ pol_p) && (out_n ^ pol_n))
      n_overlap++;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1: reset state
    chk("R1 during reset", {moe, obs()[2:0]}, 4'b0000);
    rst_n = 1'b1;
    tick(2);
    chk("R1 after reset", {moe, out_p_oe, out_n_oe, out_p}, 4'b0000);

    // Table walk over all control combinations
    ref_i = 1'b1; pol_p = 1'b0; pol_n = 1'b1; idle_p = 1'b1; idle_n = 1'b1;
    dtime = 8'd3;
    for (int i = 0; i < 32; i++) begin
      run_off  = VEC[i][7];
      idle_off = VEC[i][6];
      en_p     = VEC[i][5];
      en_n     = VEC[i][4];
      if (VEC[i][8]) write_moe(1'b1, 1'b0);
      else           write_moe(1'b0, 1'b1);
      tick(8);
      chk($sformatf("%s vector %0d", vec_tag(VEC[i][8:4]), i), obs(), VEC[i][3:0]);
    end

    // R3: single channel follows the sampled reference
    en_p = 1'b1; en_n = 1'b0; run_off = 1'b0; pol_p = 1'b1; ref_i = 1'b0;
    write_moe(1'b1, 1'b0);
    tick(4);
    chk("R3 ref low", obs(), 4'b1100);
    ref_i = 1'b1;
    tick(1);
    chk("R3 ref high next edge", obs(), 4'b1000);

    // R4: dead-time of 3 edges on each activation
    pol_p = 1'b0; pol_n = 1'b0; en_p = 1'b1; en_n = 1'b1; ref_i = 1'b0; dtime = 8'd3;
    tick(8);
    chk("R4 low steady", obs(), 4'b1011);
    ref_i = 1'b1;
    for (int k = 0; k <= 3; k++) begin
      tick(1);
      chk($sformatf("R4 rise gap k=%0d", k), obs(), {1'b1, (k == 3), 1'b1, 1'b0});
    end
    ref_i = 1'b0;
    for (int k = 0; k <= 3; k++) begin
      tick(1);
      chk($sformatf("R4 fall gap k=%0d", k), obs(), {1'b1, 1'b0, 1'b1, (k == 3)});
    end
    // R4: zero dead-time activates at the sampling edge
    dtime = 8'd0;
    tick(2);
    ref_i = 1'b1;
    tick(1);
    chk("R4 zero dead-time", obs(), 4'b1110);

    // R5: pulse shorter than dead-time is swallowed
    dtime = 8'd4; ref_i = 1'b0;
    tick(8);
    begin
      logic seen_p;
      seen_p = 1'b0;
      ref_i = 1'b1;
      tick(2);
      if (out_p) seen_p = 1'b1;
      ref_i = 1'b0;
      for (int k = 0; k < 10; k++) begin
        tick(1);
        if (out_p) seen_p = 1'b1;
      end
      chk("R5 short pulse suppressed", {3'b000, seen_p}, 4'b0000);
    end

    // R6: break with idle off-state select low floats the pair at once
    idle_off = 1'b0;
    brk = 1'b1;
    #1;
    chk("R6 break float", obs(), 4'b0000);
    tick(1);
    brk = 1'b0;
    write_moe(1'b1, 1'b0);

    // R7 / R9: break forces inactive, idle levels after D+1 edges
    pol_p = 1'b0; pol_n = 1'b1; idle_p = 1'b1; idle_n = 1'b1;
    idle_off = 1'b1; dtime = 8'd3; ref_i = 1'b0;
    tick(8);
    chk("R4 pair before break", obs(), 4'b1010);
    brk = 1'b1;
    #1;
    chk("R9 break forces inactive at once", obs(), 4'b1011);
    for (int k = 1; k <= 4; k++) begin
      tick(1);
      chk($sformatf("R7 idle wait k=%0d", k), obs(), (k <= 3) ? 4'b1011 : 4'b1111);
      if (k == 1) chk("R9 enable cleared", {3'b000, moe}, 4'b0000);
    end
    write_moe(1'b1, 1'b0);
    chk("R9 set ignored under break", {3'b000, moe}, 4'b0000);
    brk = 1'b0;
    tick(2);
    chk("R10 stays off after break", {3'b000, moe}, 4'b0000);
    write_moe(1'b1, 1'b0);
    chk("R10 set write", {3'b000, moe}, 4'b0001);
    write_moe(1'b0, 1'b1);
    chk("R10 clear write", {3'b000, moe}, 4'b0000);
    write_moe(1'b1, 1'b1);
    chk("R10 set wins", {3'b000, moe}, 4'b0001);

    // R8: idle levels that would make both active are refused
    idle_p = 1'b1; idle_n = 1'b0;
    write_moe(1'b0, 1'b1);
    tick(8);
    chk("R8 both-active idle held inactive", obs(), 4'b1011);

    tick(2);
    chk("R11 no overlap seen", {3'b000, (n_overlap != 0)}, 4'b0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule